// File: doc/BRIEF.md
# Equivalent-Time Waveform Capture Sequencer

This block turns one latched comparator into an 8-bit sampling front end for repetitive signals. It sweeps two quantities. The first is the comparator reference, set through an external DAC. The second is the phase between the capture clock and the stimulus clock, set through an external phase shifter. The phase is the outer loop and the threshold level is the inner loop.

For every phase and level pair, the block records a burst of consecutive comparator bits, one per time slot. Each slot keeps a hit count, so a slot's final count is the number of levels the signal exceeded. That count is the slot's amplitude code.

Some phase positions pick up one extra capture clock of synchronizer delay. A per-phase correction table shifts those phases back by one slot. When the sweep ends, the record is read out in slot order with the phases interleaved, so sample order is ascending effective time. Each read returns the same word position from a pair of adjacent 32-sample blocks. Readout is gated by the completion flag.

Top module: `ets_capture_seq`

## Requirements
- R1: After reset, `done` is low, neither `ph_req` nor `dac_req` is asserted, and every hit count is zero.
- R2: An accepted start runs phases 0 to PHASES-1 in ascending order. Each phase begins with `ph_req` high and `ph_idx` equal to that phase. Both are held unchanged until a cycle with `ph_ack` high. `ph_req` and `dac_req` are never high together.
- R3: Within a phase, levels 0 to LEVELS-1 are visited in ascending order. Each level raises `dac_req` with `dac_code` equal to the value written for that level through `cfg_dac_we`/`cfg_dac_addr`/`cfg_dac_data`. `dac_req` and `dac_code` are held until a cycle with `dac_ack` high.
- R4: A DAC acknowledge is taken at some clock edge. The comparator is sampled on the SLOTS edges that follow it, and those samples go to slots 0 to SLOTS-1 in order. `cmp_in` at any other time has no effect on any count.
- R5: A phase whose correction bit (written via `cfg_cor_we`/`cfg_cor_addr`/`cfg_cor_val`) is 1 samples SLOTS+1 bits after each DAC acknowledge. It discards the first bit, and the bits that follow go to slots 0 to SLOTS-1.
- R6: A slot's code is the number of levels at which its bit was 1, saturated at 2^CODE_W-1.
- R7: Record sample n = slot*PHASES + phase. A read with `rd_en` high and transfer index t, word w returns two samples one cycle later. `rd_lo` holds sample 2t*BLK_LEN+w and `rd_hi` holds sample (2t+1)*BLK_LEN+w.
- R8: An accepted start clears `done` on the next cycle, and `done` is set on the cycle after the last sample is captured. A read while `done` is low returns `rd_valid`=0 with zero data.
- R9: `start` while a sweep is running has no effect. `done` stays high until the next start.
- R10: An accepted start clears every hit count before the new sweep, so no count carries over from a previous record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a sweep (accepted only when idle) |
| done | output | 1 | Record complete |
| cmp_in | input | 1 | Latched comparator output |
| dac_req | output | 1 | Threshold change request |
| dac_code | output | DAC_W | Threshold code for the current level |
| dac_ack | input | 1 | DAC settled |
| ph_req | output | 1 | Phase change request |
| ph_idx | output | clog2(PHASES) | Requested phase position |
| ph_ack | input | 1 | Phase shifter settled |
| cfg_dac_we | input | 1 | Write strobe for the level-to-code table |
| cfg_dac_addr | input | clog2(LEVELS) | Level index to write |
| cfg_dac_data | input | DAC_W | DAC code for that level |
| cfg_cor_we | input | 1 | Write strobe for the correction table |
| cfg_cor_addr | input | clog2(PHASES) | Phase index to write |
| cfg_cor_val | input | 1 | 1 = phase arrives one slot late |
| rd_en | input | 1 | Read request |
| rd_xfer | input | clog2(SLOTS*PHASES/(2*BLK_LEN)) | Transfer (block pair) index |
| rd_word | input | clog2(BLK_LEN) | Word position inside each block |
| rd_valid | output | 1 | Read data valid |
| rd_lo | output | CODE_W | Sample from the even block |
| rd_hi | output | CODE_W | Sample from the odd block |

## Verification
The assertions check the handshake rules on every cycle: each request holds steady until its acknowledge, and the two requests never overlap. They also check that `done` gates readout, that `done` holds, and that a start from the done state drops `done` and opens a phase request.

Some behaviour can only be seen in the bench's scenarios. These are the slot mapping of each capture burst, the discarded leading bit on corrected phases, saturation of full-scale slots, and the interleaved read order across block and transfer boundaries. The bench also shows that a stray start mid-sweep leaves the handshake sequence unchanged, and that a second sweep with a different signal starts from cleared counts.

// File: rtl/ets_pkg.sv
`timescale 1ns/1ps
package ets_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PHASE = 2'd1,
      ST_LEVEL = 2'd2,
      ST_CAPT  = 2'd3
   } ets_state_t;

endpackage

// File: rtl/ets_cal_tables.sv
`timescale 1ns/1ps
// Level-to-threshold-code table and per-phase one-slot correction table.
module ets_cal_tables #(
   parameter int LEVELS = 256,
   parameter int PHASES = 40,
   parameter int DAC_W  = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_dac_we,
   input  logic [$clog2(LEVELS)-1:0] cfg_dac_addr,
   input  logic [DAC_W-1:0]          cfg_dac_data,
   input  logic                      cfg_cor_we,
   input  logic [$clog2(PHASES)-1:0] cfg_cor_addr,
   input  logic                      cfg_cor_val,
   input  logic [$clog2(LEVELS)-1:0] lv_sel,
   input  logic [$clog2(PHASES)-1:0] ph_sel,
   output logic [DAC_W-1:0]          dac_val,
   output logic                      cor_val
);
   localparam int LV_W = $clog2(LEVELS);
   localparam int PH_W = $clog2(PHASES);
   localparam int STEP = (2 ** DAC_W) / LEVELS;
   localparam logic [LV_W-1:0] LV_LAST = LV_W'(LEVELS - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

   logic [DAC_W-1:0] dac_q [LEVELS];
   logic             cor_q [PHASES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LEVELS; i++) dac_q[i] <= DAC_W'(i * STEP);
      end else if (cfg_dac_we && cfg_dac_addr <= LV_LAST) begin
         dac_q[cfg_dac_addr] <= cfg_dac_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PHASES; i++) cor_q[i] <= 1'b0;
      end else if (cfg_cor_we && cfg_cor_addr <= PH_LAST) begin
         cor_q[cfg_cor_addr] <= cfg_cor_val;
      end
   end

   assign dac_val = (lv_sel <= LV_LAST) ? dac_q[lv_sel] : '0;
   assign cor_val = (ph_sel <= PH_LAST) ? cor_q[ph_sel] : 1'b0;

endmodule

// File: rtl/ets_sweep_ctrl.sv
`timescale 1ns/1ps
// Sweep sequencer: phase outer loop, level inner loop, burst capture per pair.
module ets_sweep_ctrl
   import ets_pkg::*;
#(
   parameter int SLOTS  = 32,
   parameter int PHASES = 40,
   parameter int LEVELS = 256
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic                              ph_ack,
   input  logic                              dac_ack,
   input  logic                              cmp_in,
   input  logic                              cor_val,
   output logic                              ph_req,
   output logic [$clog2(PHASES)-1:0]         ph_idx,
   output logic                              dac_req,
   output logic [$clog2(LEVELS)-1:0]         lv_idx,
   output logic                              done,
   output logic                              clr,
   output logic                              hit_we,
   output logic [$clog2(SLOTS*PHASES)-1:0]   hit_addr
);
   localparam int PH_W  = $clog2(PHASES);
   localparam int LV_W  = $clog2(LEVELS);
   localparam int SL_W  = $clog2(SLOTS);
   localparam int K_W   = $clog2(SLOTS + 1);
   localparam int IDX_W = $clog2(SLOTS * PHASES);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PHASES - 1);
   localparam logic [LV_W-1:0]  LV_LAST = LV_W'(LEVELS - 1);
   localparam logic [K_W-1:0]   K_LAST  = K_W'(SLOTS - 1);
   localparam logic [IDX_W-1:0] PH_CNT  = IDX_W'(PHASES);

   ets_state_t       st_q;
   logic [PH_W-1:0]  ph_q;
   logic [LV_W-1:0]  lv_q;
   logic [K_W-1:0]   k_q;
   logic             done_q;

   logic [K_W-1:0]   shift, k_end, slot_k;
   logic             k_done, slot_ok;

   // A late phase samples one extra bit and drops the first one.
   assign shift   = K_W'(cor_val);
   assign k_end   = K_LAST + shift;
   assign k_done  = (k_q == k_end);
   assign slot_ok = (k_q >= shift);
   assign slot_k  = k_q - shift;

   assign hit_addr = IDX_W'(slot_k[SL_W-1:0]) * PH_CNT + IDX_W'(ph_q);
   assign hit_we   = (st_q == ST_CAPT) && slot_ok && cmp_in;
   assign clr      = (st_q == ST_IDLE) && start;
   assign ph_req   = (st_q == ST_PHASE);
   assign dac_req  = (st_q == ST_LEVEL);
   assign ph_idx   = ph_q;
   assign lv_idx   = lv_q;
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= '0;
         lv_q   <= '0;
         k_q    <= '0;
         done_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  done_q <= 1'b0;
                  ph_q   <= '0;
                  lv_q   <= '0;
                  st_q   <= ST_PHASE;
               end
            end
            ST_PHASE: begin
               if (ph_ack) begin
                  lv_q <= '0;
                  st_q <= ST_LEVEL;
               end
            end
            ST_LEVEL: begin
               if (dac_ack) begin
                  k_q  <= '0;
                  st_q <= ST_CAPT;
               end
            end
            ST_CAPT: begin
               if (k_done) begin
                  if (lv_q == LV_LAST) begin
                     if (ph_q == PH_LAST) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        ph_q <= ph_q + PH_W'(1);
                        st_q <= ST_PHASE;
                     end
                  end else begin
                     lv_q <= lv_q + LV_W'(1);
                     st_q <= ST_LEVEL;
                  end
               end else begin
                  k_q <= k_q + K_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ets_hit_store.sv
`timescale 1ns/1ps
// Per-sample hit counters in record order, with paired-block readout.
module ets_hit_store #(
   parameter int SLOTS   = 32,
   parameter int PHASES  = 40,
   parameter int LEVELS  = 256,
   parameter int CODE_W  = 8,
   parameter int BLK_LEN = 32
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             clr,
   input  logic                                             hit_we,
   input  logic [$clog2(SLOTS*PHASES)-1:0]                  hit_addr,
   input  logic                                             done,
   input  logic                                             rd_en,
   input  logic [$clog2(SLOTS*PHASES/(2*BLK_LEN))-1:0]      rd_xfer,
   input  logic [$clog2(BLK_LEN)-1:0]                       rd_word,
   output logic                                             rd_valid,
   output logic [CODE_W-1:0]                                rd_lo,
   output logic [CODE_W-1:0]                                rd_hi
);
   localparam int N     = SLOTS * PHASES;
   localparam int IDX_W = $clog2(N);
   localparam int NXFER = N / (2 * BLK_LEN);
   localparam int XF_W  = $clog2(NXFER);
   localparam int MAXC  = (2 ** CODE_W) - 1;
   localparam logic [XF_W-1:0]   XF_LAST = XF_W'(NXFER - 1);
   localparam logic [CODE_W-1:0] CODE_MX = CODE_W'(MAXC);

   logic [CODE_W-1:0] mem_q [N];
   logic [CODE_W-1:0] cur, nxt;
   logic [IDX_W-1:0]  a_lo, a_hi;
   logic              rd_ok;

   assign cur = mem_q[hit_addr];

   generate
      if (MAXC >= LEVELS) begin : g_plain
         assign nxt = cur + CODE_W'(1);
      end else begin : g_sat
         assign nxt = (cur == CODE_MX) ? cur : cur + CODE_W'(1);
      end
   endgenerate

   assign a_lo  = {rd_xfer, 1'b0, rd_word};
   assign a_hi  = {rd_xfer, 1'b1, rd_word};
   assign rd_ok = rd_en && done && (rd_xfer <= XF_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem_q[i] <= '0;
         rd_valid <= 1'b0;
         rd_lo    <= '0;
         rd_hi    <= '0;
      end else begin
         if (clr) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
         end else if (hit_we) begin
            mem_q[hit_addr] <= nxt;
         end
         rd_valid <= rd_ok;
         rd_lo    <= rd_ok ? mem_q[a_lo] : '0;
         rd_hi    <= rd_ok ? mem_q[a_hi] : '0;
      end
   end

endmodule

// File: rtl/ets_capture_seq.sv
`timescale 1ns/1ps
// Top: equivalent-time capture sequencer.
module ets_capture_seq #(
   parameter int SLOTS   = 32,
   parameter int PHASES  = 40,
   parameter int LEVELS  = 256,
   parameter int CODE_W  = 8,
   parameter int DAC_W   = 12,
   parameter int BLK_LEN = 32
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         start,
   output logic                                         done,
   input  logic                                         cmp_in,
   output logic                                         dac_req,
   output logic [DAC_W-1:0]                             dac_code,
   input  logic                                         dac_ack,
   output logic                                         ph_req,
   output logic [$clog2(PHASES)-1:0]                    ph_idx,
   input  logic                                         ph_ack,
   input  logic                                         cfg_dac_we,
   input  logic [$clog2(LEVELS)-1:0]                    cfg_dac_addr,
   input  logic [DAC_W-1:0]                             cfg_dac_data,
   input  logic                                         cfg_cor_we,
   input  logic [$clog2(PHASES)-1:0]                    cfg_cor_addr,
   input  logic                                         cfg_cor_val,
   input  logic                                         rd_en,
   input  logic [$clog2(SLOTS*PHASES/(2*BLK_LEN))-1:0]  rd_xfer,
   input  logic [$clog2(BLK_LEN)-1:0]                   rd_word,
   output logic                                         rd_valid,
   output logic [CODE_W-1:0]                            rd_lo,
   output logic [CODE_W-1:0]                            rd_hi
);
   localparam int N     = SLOTS * PHASES;
   localparam int IDX_W = $clog2(N);
   localparam int LV_W  = $clog2(LEVELS);
   localparam int WD_W  = $clog2(BLK_LEN);
   localparam int NXFER = N / (2 * BLK_LEN);
   localparam int XF_W  = $clog2(NXFER);

   // Elaboration-time parameter checks.
   generate
      if (SLOTS < 2 || PHASES < 2 || LEVELS < 2) begin : g_bad_dims
         $error("SLOTS, PHASES and LEVELS must each be at least 2");
      end
      if ((2 ** WD_W) != BLK_LEN) begin : g_bad_blk
         $error("BLK_LEN must be a power of two");
      end
      if ((N % (2 * BLK_LEN)) != 0 || NXFER < 2) begin : g_bad_pairs
         $error("record must hold at least two whole block pairs");
      end
      if (XF_W + 1 + WD_W != IDX_W) begin : g_bad_addr
         $error("readout address does not cover the record");
      end
      if (DAC_W < LV_W || CODE_W < 1 || CODE_W > 16) begin : g_bad_width
         $error("DAC_W must cover LEVELS and CODE_W must be 1..16");
      end
   endgenerate

   logic                 clr, hit_we, cor_val;
   logic [IDX_W-1:0]     hit_addr;
   logic [LV_W-1:0]      lv_idx;

   ets_cal_tables #(
      .LEVELS (LEVELS),
      .PHASES (PHASES),
      .DAC_W  (DAC_W)
   ) u_tables (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_dac_we   (cfg_dac_we),
      .cfg_dac_addr (cfg_dac_addr),
      .cfg_dac_data (cfg_dac_data),
      .cfg_cor_we   (cfg_cor_we),
      .cfg_cor_addr (cfg_cor_addr),
      .cfg_cor_val  (cfg_cor_val),
      .lv_sel       (lv_idx),
      .ph_sel       (ph_idx),
      .dac_val      (dac_code),
      .cor_val      (cor_val)
   );

   ets_sweep_ctrl #(
      .SLOTS  (SLOTS),
      .PHASES (PHASES),
      .LEVELS (LEVELS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ph_ack   (ph_ack),
      .dac_ack  (dac_ack),
      .cmp_in   (cmp_in),
      .cor_val  (cor_val),
      .ph_req   (ph_req),
      .ph_idx   (ph_idx),
      .dac_req  (dac_req),
      .lv_idx   (lv_idx),
      .done     (done),
      .clr      (clr),
      .hit_we   (hit_we),
      .hit_addr (hit_addr)
   );

   ets_hit_store #(
      .SLOTS   (SLOTS),
      .PHASES  (PHASES),
      .LEVELS  (LEVELS),
      .CODE_W  (CODE_W),
      .BLK_LEN (BLK_LEN)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .hit_we   (hit_we),
      .hit_addr (hit_addr),
      .done     (done),
      .rd_en    (rd_en),
      .rd_xfer  (rd_xfer),
      .rd_word  (rd_word),
      .rd_valid (rd_valid),
      .rd_lo    (rd_lo),
      .rd_hi    (rd_hi)
   );

endmodule

// File: rtl/ets_capture_seq_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker, bound into the top module.
module ets_capture_seq_chk #(
   parameter int PHASES = 40,
   parameter int DAC_W  = 12,
   parameter int CODE_W = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic                      done,
   input logic                      dac_req,
   input logic [DAC_W-1:0]          dac_code,
   input logic                      dac_ack,
   input logic                      ph_req,
   input logic [$clog2(PHASES)-1:0] ph_idx,
   input logic                      ph_ack,
   input logic                      rd_en,
   input logic                      rd_valid,
   input logic [CODE_W-1:0]         rd_lo,
   input logic [CODE_W-1:0]         rd_hi
);

   assert_ph_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_req && !ph_ack) |=> (ph_req && $stable(ph_idx)));

   assert_req_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_req && dac_req));

   assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_req && !dac_ack) |=> (dac_req && $stable(dac_code)));

   assert_rd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !done) |=> (!rd_valid && rd_lo == '0 && rd_hi == '0));

   assert_busy_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_req || dac_req) |-> !done);

   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!done && ph_req && ph_idx == '0));

   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

endmodule

bind ets_capture_seq ets_capture_seq_chk #(
   .PHASES (PHASES),
   .DAC_W  (DAC_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .done     (done),
   .dac_req  (dac_req),
   .dac_code (dac_code),
   .dac_ack  (dac_ack),
   .ph_req   (ph_req),
   .ph_idx   (ph_idx),
   .ph_ack   (ph_ack),
   .rd_en    (rd_en),
   .rd_valid (rd_valid),
   .rd_lo    (rd_lo),
   .rd_hi    (rd_hi)
);

// File: tb/ets_capture_seq_bench.sv
`timescale 1ns/1ps
module ets_capture_seq_bench;
   localparam int SLOTS   = 32;
   localparam int PHASES  = 4;
   localparam int LEVELS  = 8;
   localparam int CODE_W  = 3;
   localparam int DAC_W   = 12;
   localparam int BLK_LEN = 32;
   localparam int N       = SLOTS * PHASES;
   localparam int NXFER   = N / (2 * BLK_LEN);
   localparam int MAXC    = (2 ** CODE_W) - 1;

   // Readout probes for seed 0: {xfer, word, expected lo, expected hi}.
   localparam int PRB [6][4] = '{
      '{0,  0, 0, 4},
      '{0,  7, 7, 3},
      '{0, 31, 7, 1},
      '{1,  0, 7, 2},
      '{1, 31, 5, 7},
      '{1, 12, 2, 6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic cmp_in = 1'b1;
   logic dac_ack = 1'b0;
   logic ph_ack = 1'b0;
   logic cfg_dac_we = 1'b0;
   logic [2:0] cfg_dac_addr = '0;
   logic [DAC_W-1:0] cfg_dac_data = '0;
   logic cfg_cor_we = 1'b0;
   logic [1:0] cfg_cor_addr = '0;
   logic cfg_cor_val = 1'b0;
   logic rd_en = 1'b0;
   logic [0:0] rd_xfer = '0;
   logic [4:0] rd_word = '0;
   logic done, dac_req, ph_req, rd_valid;
   logic [DAC_W-1:0] dac_code;
   logic [1:0] ph_idx;
   logic [CODE_W-1:0] rd_lo, rd_hi;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int seed = 0;
   int ph_hs = 0;
   int dac_hs = 0;

   always #10 clk = ~clk;

   ets_capture_seq #(
      .SLOTS(SLOTS), .PHASES(PHASES), .LEVELS(LEVELS),
      .CODE_W(CODE_W), .DAC_W(DAC_W), .BLK_LEN(BLK_LEN)
   ) u_ets_capture_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .cmp_in(cmp_in),
      .dac_req(dac_req), .dac_code(dac_code), .dac_ack(dac_ack),
      .ph_req(ph_req), .ph_idx(ph_idx), .ph_ack(ph_ack),
      .cfg_dac_we(cfg_dac_we), .cfg_dac_addr(cfg_dac_addr), .cfg_dac_data(cfg_dac_data),
      .cfg_cor_we(cfg_cor_we), .cfg_cor_addr(cfg_cor_addr), .cfg_cor_val(cfg_cor_val),
      .rd_en(rd_en), .rd_xfer(rd_xfer), .rd_word(rd_word),
      .rd_valid(rd_valid), .rd_lo(rd_lo), .rd_hi(rd_hi)
   );

   function automatic int cor_b(input int p);
      return (p == 1 || p == 2) ? 1 : 0;
   endfunction

   function automatic int dac_b(input int l);
      return (l * 411 + 5) % 4096;
   endfunction

   function automatic int amp(input int s, input int n);
      return (n * 7 + s * 3) % 10;
   endfunction

   function automatic int exp_code(input int s, input int n);
      int h;
      h = (amp(s, n) < LEVELS) ? amp(s, n) : LEVELS;
      return (h > MAXC) ? MAXC : h;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // External DAC / phase shifter / comparator model.
   initial begin
      int cur_ph, cur_lv, cap_k, ph_wait, dac_wait, s;
      cur_ph = 0; cur_lv = -1; cap_k = -1; ph_wait = 0; dac_wait = 0;
      forever begin
         @(negedge clk);
         // R4/R5: burst of comparator bits; outside the window drive 1 as noise.
         if (cap_k >= 0 && cap_k < SLOTS + cor_b(cur_ph)) begin
            s = cap_k - cor_b(cur_ph);
            cmp_in = (s < 0) ? 1'b1 : (amp(seed, s * PHASES + cur_ph) > cur_lv);
            cap_k++;
         end else begin
            cap_k = -1;
            cmp_in = 1'b1;
         end
         ph_ack = 1'b0;
         if (ph_req) begin
            ph_wait++;
            if (ph_wait == 2) begin
               chk(ph_idx == 2'(ph_hs), "R2 phase order", int'(ph_idx), ph_hs);
               cur_ph = int'(ph_idx);
               cur_lv = -1;
               ph_ack = 1'b1;
               ph_hs++;
            end
         end else ph_wait = 0;
         dac_ack = 1'b0;
         if (dac_req) begin
            dac_wait++;
            if (dac_wait == 3) begin
               cur_lv++;
               chk(int'(dac_code) == dac_b(cur_lv), "R3 dac code", int'(dac_code), dac_b(cur_lv));
               dac_ack = 1'b1;
               cap_k = 0;
               dac_hs++;
            end
         end else dac_wait = 0;
      end
   end

   task automatic read_pair(input int x, input int w);
      rd_en = 1'b1;
      rd_xfer = 1'(x);
      rd_word = 5'(w);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic sweep(input int sd, input string force_tag);
      for (int x = 0; x < NXFER; x++) begin
         for (int w = 0; w < BLK_LEN; w++) begin
            int nl, nh;
            string tl, th;
            read_pair(x, w);
            nl = 2 * x * BLK_LEN + w;
            nh = nl + BLK_LEN;
            tl = (force_tag != "") ? force_tag : (cor_b(nl % PHASES) == 1 ? "R5" : "R4");
            th = (force_tag != "") ? force_tag : (cor_b(nh % PHASES) == 1 ? "R5" : "R4");
            chk(rd_valid && int'(rd_lo) == exp_code(sd, nl), tl, int'(rd_lo), exp_code(sd, nl));
            chk(rd_valid && int'(rd_hi) == exp_code(sd, nh), th, int'(rd_hi), exp_code(sd, nh));
         end
      end
   endtask

   task automatic run_sweep(input int sd, input bit poke);
      seed = sd;
      ph_hs = 0;
      dac_hs = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R8 done cleared on start", int'(done), 0);
      if (poke) begin
         repeat (200) @(negedge clk);
         // R9: stray start mid-sweep; R8: read while busy.
         start = 1'b1;
         rd_en = 1'b1;
         rd_xfer = 1'b0;
         rd_word = 5'd7;
         @(negedge clk);
         start = 1'b0;
         rd_en = 1'b0;
         chk(rd_valid == 1'b0 && rd_lo == '0, "R8 read while busy", int'(rd_valid), 0);
      end
      while (!done) @(negedge clk);
      chk(ph_hs == PHASES, "R9 phase handshakes", ph_hs, PHASES);
      chk(dac_hs == PHASES * LEVELS, "R3 level handshakes", dac_hs, PHASES * LEVELS);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state.
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(ph_req == 1'b0 && dac_req == 1'b0, "R1 requests", int'({ph_req, dac_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int l = 0; l < LEVELS; l++) begin
         cfg_dac_we = 1'b1;
         cfg_dac_addr = 3'(l);
         cfg_dac_data = 12'(dac_b(l));
         @(negedge clk);
      end
      cfg_dac_we = 1'b0;
      for (int p = 0; p < PHASES; p++) begin
         cfg_cor_we = 1'b1;
         cfg_cor_addr = 2'(p);
         cfg_cor_val = 1'(cor_b(p));
         @(negedge clk);
      end
      cfg_cor_we = 1'b0;
      // R8: no record yet.
      read_pair(0, 0);
      chk(rd_valid == 1'b0 && rd_lo == '0 && rd_hi == '0, "R8 read before done", int'(rd_valid), 0);

      run_sweep(0, 1'b1);

      // R7/R6: probe table, including block and transfer edges and saturation.
      for (int i = 0; i < 6; i++) begin
         read_pair(PRB[i][0], PRB[i][1]);
         chk(rd_valid && int'(rd_lo) == PRB[i][2], "R7 probe lo", int'(rd_lo), PRB[i][2]);
         chk(rd_valid && int'(rd_hi) == PRB[i][3], "R6 probe hi", int'(rd_hi), PRB[i][3]);
      end
      sweep(0, "");

      repeat (20) @(negedge clk);
      chk(done == 1'b1, "R9 done holds", int'(done), 1);

      // R10: second record with a different signal must start from zero.
      run_sweep(1, 1'b0);
      sweep(1, "R10");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule